// File: doc/BRIEF.md
# Instruction Operand Fetch and Address Generator

This block turns one instruction operand into a usable result. A sequencer pulses `op_start` with an 8-bit format code. The block then pulls as many 16-bit words as that format needs from a ready/valid word stream. For register operands it reads a one-port register file. It answers with a single-cycle `done` pulse. The result is one of three things: a register value, a 64-bit immediate, or a memory effective address with its access size. If the operand is malformed or not permitted, the result is a fault code instead.

The format code carries the addressing mode in bits 7:4 and the access-size code in bits 3:0. The modes are 0 register, 1 immediate, 2 absolute memory, 3 register pair, 4 register pair plus displacement, and 5 register pair plus scale and displacement. The size code matters only for the memory modes (2 to 5). The register file has 64 entries. Index 0 is the null register, which reads as zero wherever it is allowed. Each register also reports a flag marking it as system-only. The flag is checked against the `user_mode` input.

Top module: `opnd_fetch`

## Requirements
- R1: Mode 0 consumes exactly one word, which is the register index. The result kind is 0 (register) and `res_val` is the content of that register.
- R2: Mode 1 consumes four words. The first word lands in `res_val[15:0]`, the second in bits 31:16, the third in bits 47:32 and the fourth in bits 63:48. The result kind is 1 (immediate).
- R3: Mode 2 consumes four words and builds `res_addr` from them in the same word order as R2. The result kind is 2 (memory).
- R4: In the memory modes, size codes 0, 1, 2 and 3 give `res_size` of 1, 2, 4 and 8 bytes. Codes 4 to 15 give fault code 1 (illegal) without consuming any word.
- R5: In modes 3 to 5, the first word carries the base index in bits 15:8 and the index-register index in bits 7:0. Mode 3 reads no further word and uses scale 1 and displacement 0.
- R6: Mode 4 reads one more word as the displacement, with scale 1. Mode 5 reads the scale word and then the displacement word.
- R7: The effective address is base + index × sign-extended scale + sign-extended displacement, taken modulo 2^64.
- R8: A register index of 64 or more gives fault code 1. Word consumption stops with the word that carried it.
- R9: Index 0 used as a mode-0 operand gives fault code 1. As a base or index in modes 3 to 5 it is accepted and contributes zero, whatever the register file returns.
- R10: Reading a register, other than index 0, whose system flag is set while `user_mode` is 1 gives fault code 2 (privilege).
- R11: A mode code of 6 or more gives fault code 1 without consuming any word.
- R12: `done` lasts exactly one cycle per operation, and `op_start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Begin parsing one operand (taken only when idle) |
| op_fmt | input | 8 | Format: mode in bits 7:4, size code in bits 3:0 |
| user_mode | input | 1 | 1 when the current privilege level is user |
| busy | output | 1 | An operation is in progress |
| wd_valid | input | 1 | Instruction word present |
| wd_data | input | 16 | Instruction word |
| wd_ready | output | 1 | Block takes a word this cycle |
| rf_addr | output | 6 | Register file read index |
| rf_data | input | 64 | Register file read data (same cycle) |
| rf_sys | input | 1 | System-only flag of the register read |
| done | output | 1 | One-cycle result strobe |
| res_kind | output | 2 | 0 register, 1 immediate, 2 memory |
| res_val | output | 64 | Register value or immediate |
| res_addr | output | 64 | Effective address |
| res_size | output | 4 | Access size in bytes (memory kinds) |
| res_fault | output | 2 | 0 none, 1 illegal, 2 privilege |

## Verification
When words arrive back to back, `done` comes 1 cycle after the start edge for a format rejected outright. It comes 2 cycles after for an out-of-range index. A register operand takes 3 cycles and an immediate or absolute address takes 5. A register-pair operand takes 5 plus its extra words. A privilege fault on the base arrives two cycles earlier than the full result, and one on the index one cycle earlier. The bench counts falling edges from the start edge to `done` and compares that count against this table. It does so only on runs without stream gaps. It also counts accepted handshakes, to confirm how many words each format consumed.

// File: rtl/opf_pkg.sv
package opf_pkg;

  localparam logic [3:0] M_REG  = 4'd0;
  localparam logic [3:0] M_IMM  = 4'd1;
  localparam logic [3:0] M_ABS  = 4'd2;
  localparam logic [3:0] M_RR   = 4'd3;
  localparam logic [3:0] M_RRD  = 4'd4;
  localparam logic [3:0] M_RRSD = 4'd5;

  typedef enum logic [1:0] {
    K_REG = 2'd0,
    K_IMM = 2'd1,
    K_MEM = 2'd2
  } kind_t;

  typedef enum logic [1:0] {
    F_NONE = 2'd0,
    F_ILL  = 2'd1,
    F_PRIV = 2'd2
  } fault_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WORDS,
    S_RD1,
    S_RD2,
    S_AGU,
    S_FIN
  } state_t;

endpackage

// File: rtl/opf_fmt_dec.sv
module opf_fmt_dec
  import opf_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int CW    = 3
) (
  input  logic [7:0]    fmt,
  output logic          mode_ok,
  output logic          is_mem,
  output logic          is_rr,
  output logic          size_ok,
  output logic [3:0]    size_b,
  output logic [CW-1:0] nwords,
  output kind_t         kind
);

  logic [3:0] mode;
  assign mode = fmt[7:4];

  always_comb begin
    mode_ok = 1'b1;
    is_mem  = 1'b0;
    is_rr   = 1'b0;
    kind    = K_REG;
    nwords  = CW'(1);
    case (mode)
      M_REG:  begin kind = K_REG; nwords = CW'(1); end
      M_IMM:  begin kind = K_IMM; nwords = CW'(NSLOT); end
      M_ABS:  begin kind = K_MEM; is_mem = 1'b1; nwords = CW'(NSLOT); end
      M_RR:   begin kind = K_MEM; is_mem = 1'b1; is_rr = 1'b1; nwords = CW'(1); end
      M_RRD:  begin kind = K_MEM; is_mem = 1'b1; is_rr = 1'b1; nwords = CW'(2); end
      M_RRSD: begin kind = K_MEM; is_mem = 1'b1; is_rr = 1'b1; nwords = CW'(3); end
      default: mode_ok = 1'b0;
    endcase
  end

  // size code: 0..3 -> 1,2,4,8 bytes; anything wider is rejected
  assign size_ok = (fmt[3:2] == 2'b00);
  assign size_b  = 4'b0001 << fmt[1:0];

endmodule

// File: rtl/opf_idx_chk.sv
module opf_idx_chk #(
  parameter int IN_W = 8,
  parameter int NREG = 64,
  parameter int INV  = 0
) (
  input  logic [IN_W-1:0] idx,
  output logic            ok_direct,
  output logic            ok_mem
);

  logic [31:0] idx32;
  logic        in_range;
  logic        is_inv;

  assign idx32     = {{(32-IN_W){1'b0}}, idx};
  assign in_range  = idx32 < 32'(NREG);
  assign is_inv    = idx32 == 32'(INV);
  assign ok_mem    = in_range;
  assign ok_direct = in_range && !is_inv;

endmodule

// File: rtl/opf_agu.sv
module opf_agu #(
  parameter int XLEN = 64,
  parameter int WW   = 16
) (
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] index,
  input  logic [WW-1:0]   scale,
  input  logic [WW-1:0]   disp,
  output logic [XLEN-1:0] addr
);

  logic [XLEN-1:0] scale_x;
  logic [XLEN-1:0] disp_x;

  assign scale_x = {{(XLEN-WW){scale[WW-1]}}, scale};
  assign disp_x  = {{(XLEN-WW){disp[WW-1]}}, disp};
  assign addr    = base + index * scale_x + disp_x;

endmodule

// File: rtl/opnd_fetch.sv
module opnd_fetch
  import opf_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WW   = 16,
  parameter int NREG = 64,
  parameter int INV  = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_start,
  input  logic [7:0]      op_fmt,
  input  logic            user_mode,
  output logic            busy,
  input  logic            wd_valid,
  input  logic [WW-1:0]   wd_data,
  output logic            wd_ready,
  output logic [$clog2(NREG)-1:0] rf_addr,
  input  logic [XLEN-1:0] rf_data,
  input  logic            rf_sys,
  output logic            done,
  output logic [1:0]      res_kind,
  output logic [XLEN-1:0] res_val,
  output logic [XLEN-1:0] res_addr,
  output logic [3:0]      res_size,
  output logic [1:0]      res_fault
);

  localparam int IW    = $clog2(NREG);
  localparam int NSLOT = XLEN / WW;
  localparam int SW    = $clog2(NSLOT);
  localparam int CW    = $clog2(NSLOT + 1);
  localparam int BW    = WW / 2;

  state_t          st;
  logic [7:0]      fmt_q;
  logic [SW-1:0]   wcnt;
  logic [WW-1:0]   slot_q [NSLOT];
  logic [IW-1:0]   ia_q, ib_q;
  logic [XLEN-1:0] va_q, vb_q;

  // decode live format while idle, latched one afterwards
  logic [7:0]    dec_fmt;
  logic          d_mode_ok, d_is_mem, d_is_rr, d_size_ok;
  logic [3:0]    d_size_b;
  logic [CW-1:0] d_nwords;
  kind_t         d_kind;

  assign dec_fmt = (st == S_IDLE) ? op_fmt : fmt_q;

  opf_fmt_dec #(.NSLOT(NSLOT), .CW(CW)) u_dec (
    .fmt     (dec_fmt),
    .mode_ok (d_mode_ok),
    .is_mem  (d_is_mem),
    .is_rr   (d_is_rr),
    .size_ok (d_size_ok),
    .size_b  (d_size_b),
    .nwords  (d_nwords),
    .kind    (d_kind)
  );

  // index legality for the direct form and for both halves of a pair word
  logic w_ok_direct, w_ok_mem_unused;
  logic [1:0] pair_ok;

  opf_idx_chk #(.IN_W(WW), .NREG(NREG), .INV(INV)) u_chk_w (
    .idx       (wd_data),
    .ok_direct (w_ok_direct),
    .ok_mem    (w_ok_mem_unused)
  );

  for (genvar b = 0; b < 2; b++) begin : g_pair
    logic dir_unused;
    opf_idx_chk #(.IN_W(BW), .NREG(NREG), .INV(INV)) u_chk_b (
      .idx       (wd_data[b*BW +: BW]),
      .ok_direct (dir_unused),
      .ok_mem    (pair_ok[b])
    );
  end

  // immediate assembly: the last word comes straight from the stream
  logic [XLEN-1:0] imm_cat;
  for (genvar s = 0; s < NSLOT; s++) begin : g_cat
    if (s == NSLOT - 1) begin : g_last
      assign imm_cat[s*WW +: WW] = wd_data;
    end else begin : g_prev
      assign imm_cat[s*WW +: WW] = slot_q[s];
    end
  end

  // register read path
  logic [IW-1:0]   rd_idx;
  logic            rd_inv;
  logic [XLEN-1:0] rd_val;
  logic            rd_priv;

  assign rd_idx  = (st == S_RD2) ? ib_q : ia_q;
  assign rf_addr = rd_idx;
  assign rd_inv  = (rd_idx == IW'(INV));
  assign rd_val  = rd_inv ? '0 : rf_data;
  assign rd_priv = !rd_inv && rf_sys && user_mode;

  // scale and displacement selected by mode
  logic [3:0]      mode_q;
  logic [WW-1:0]   agu_scale, agu_disp;
  logic [XLEN-1:0] agu_addr;

  assign mode_q    = fmt_q[7:4];
  assign agu_scale = (mode_q == M_RRSD) ? slot_q[1] : WW'(1);
  assign agu_disp  = (mode_q == M_RRSD) ? slot_q[2] :
                     (mode_q == M_RRD)  ? slot_q[1] : '0;

  opf_agu #(.XLEN(XLEN), .WW(WW)) u_agu (
    .base  (va_q),
    .index (vb_q),
    .scale (agu_scale),
    .disp  (agu_disp),
    .addr  (agu_addr)
  );

  logic accept, last_word;
  assign busy      = (st != S_IDLE);
  assign wd_ready  = (st == S_WORDS);
  assign accept    = wd_ready && wd_valid;
  assign last_word = (CW'(wcnt) == d_nwords - CW'(1));
  assign done      = (st == S_FIN);

  always_ff @(posedge clk) begin
    if (accept) slot_q[wcnt] <= wd_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      fmt_q     <= '0;
      wcnt      <= '0;
      ia_q      <= '0;
      ib_q      <= '0;
      va_q      <= '0;
      vb_q      <= '0;
      res_kind  <= '0;
      res_val   <= '0;
      res_addr  <= '0;
      res_size  <= '0;
      res_fault <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (op_start) begin
            fmt_q     <= op_fmt;
            wcnt      <= '0;
            res_kind  <= d_kind;
            res_val   <= '0;
            res_addr  <= '0;
            res_size  <= d_is_mem ? d_size_b : 4'd0;
            res_fault <= F_NONE;
            if (!d_mode_ok || (d_is_mem && !d_size_ok)) begin
              res_fault <= F_ILL;
              st        <= S_FIN;
            end else begin
              st <= S_WORDS;
            end
          end
        end
        S_WORDS: begin
          if (accept) begin
            wcnt <= wcnt + SW'(1);
            if (mode_q == M_REG) begin
              if (!w_ok_direct) begin
                res_fault <= F_ILL;
                st        <= S_FIN;
              end else begin
                ia_q <= wd_data[IW-1:0];
                st   <= S_RD1;
              end
            end else if (d_is_rr) begin
              if (wcnt == '0) begin
                ia_q <= wd_data[BW +: IW];
                ib_q <= wd_data[0 +: IW];
              end
              if (wcnt == '0 && !(pair_ok[0] && pair_ok[1])) begin
                res_fault <= F_ILL;
                st        <= S_FIN;
              end else if (last_word) begin
                st <= S_RD1;
              end
            end else if (last_word) begin
              if (mode_q == M_IMM) res_val  <= imm_cat;
              else                 res_addr <= imm_cat;
              st <= S_FIN;
            end
          end
        end
        S_RD1: begin
          if (rd_priv) begin
            res_fault <= F_PRIV;
            st        <= S_FIN;
          end else begin
            va_q <= rd_val;
            if (mode_q == M_REG) begin
              res_val <= rd_val;
              st      <= S_FIN;
            end else begin
              st <= S_RD2;
            end
          end
        end
        S_RD2: begin
          if (rd_priv) begin
            res_fault <= F_PRIV;
            st        <= S_FIN;
          end else begin
            vb_q <= rd_val;
            st   <= S_AGU;
          end
        end
        S_AGU: begin
          res_addr <= agu_addr;
          st       <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // ---------------------------------------------------------------
  // assertions
  // ---------------------------------------------------------------
  logic [CW:0] taken_cnt;
  always_ff @(posedge clk) begin
    if (rst)                       taken_cnt <= '0;
    else if (op_start && !busy)    taken_cnt <= '0;
    else if (accept)               taken_cnt <= taken_cnt + (CW+1)'(1);
  end

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r11_bad_mode: assert property (@(posedge clk) disable iff (rst)
    (op_start && !busy && op_fmt[7:4] > M_RRSD) |=> (done && res_fault == F_ILL));

  a_r4_bad_size: assert property (@(posedge clk) disable iff (rst)
    (op_start && !busy && op_fmt[7:4] >= M_ABS && op_fmt[7:4] <= M_RRSD
     && op_fmt[3:2] != 2'b00) |=> (done && res_fault == F_ILL));

  a_r4_size_onehot: assert property (@(posedge clk) disable iff (rst)
    (done && res_fault == F_NONE && res_kind == K_MEM) |-> $onehot(res_size));

  a_r2_word_cap: assert property (@(posedge clk) disable iff (rst)
    taken_cnt <= (CW+1)'(NSLOT));

  a_r9_null_direct: assert property (@(posedge clk) disable iff (rst)
    (accept && mode_q == M_REG && wd_data == WW'(INV)) |=> (done && res_fault == F_ILL));

  a_r8_stop_after_fault: assert property (@(posedge clk) disable iff (rst)
    (accept && d_is_rr && wcnt == '0 && !(pair_ok[0] && pair_ok[1])) |=> (done && !wd_ready));

endmodule

// File: tb/test_opnd_fetch.sv
module test_opnd_fetch;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_start;
  logic [7:0]  op_fmt;
  logic        user_mode;
  logic        busy;
  logic        wd_valid;
  logic [15:0] wd_data;
  logic        wd_ready;
  logic [5:0]  rf_addr;
  logic [63:0] rf_data;
  logic        rf_sys;
  logic        done;
  logic [1:0]  res_kind;
  logic [63:0] res_val;
  logic [63:0] res_addr;
  logic [3:0]  res_size;
  logic [1:0]  res_fault;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  opnd_fetch i_opnd_fetch (
    .clk(clk), .rst(rst), .op_start(op_start), .op_fmt(op_fmt),
    .user_mode(user_mode), .busy(busy), .wd_valid(wd_valid),
    .wd_data(wd_data), .wd_ready(wd_ready), .rf_addr(rf_addr),
    .rf_data(rf_data), .rf_sys(rf_sys), .done(done),
    .res_kind(res_kind), .res_val(res_val), .res_addr(res_addr),
    .res_size(res_size), .res_fault(res_fault)
  );

  function automatic logic [63:0] reg_raw(input int i);
    if (i == 0) return 64'hDEAD_BEEF_0BAD_F00D;
    return 64'h9E37_79B9_7F4A_7C15 * 64'(i) + 64'(i);
  endfunction

  function automatic bit reg_sys(input int i);
    return (i >= 60) || (i == 0);
  endfunction

  always_comb begin
    rf_data = reg_raw(int'(rf_addr));
    rf_sys  = reg_sys(int'(rf_addr));
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model built from the requirements
  task automatic model(input int mode, input int sz, input logic [63:0] wv,
                       input bit um, output int ef, output int ek,
                       output logic [63:0] ev, output logic [63:0] ea,
                       output int es, output int ecn, output int elat,
                       output string tag);
    int b, x, ext, w0;
    logic [63:0] vb, vx, sc, dp;
    ev = 0; ea = 0; es = 0; ef = 0; ek = 0; ecn = 0; elat = 1; tag = "R11";
    w0 = int'(wv[15:0]);
    if (mode > 5) begin
      ef = 1; tag = "R11";
    end else if (mode >= 2 && sz > 3) begin
      ef = 1; tag = "R4";
    end else if (mode == 0) begin
      ek = 0; ecn = 1;
      if (w0 >= 64 || w0 == 0) begin
        ef = 1; elat = 2; tag = (w0 == 0) ? "R9" : "R8";
      end else if (reg_sys(w0) && um) begin
        ef = 2; elat = 3; tag = "R10";
      end else begin
        ev = reg_raw(w0); elat = 3; tag = "R1";
      end
    end else if (mode == 1) begin
      ek = 1; ecn = 4; elat = 5; ev = wv; tag = "R2";
    end else if (mode == 2) begin
      ek = 2; ecn = 4; elat = 5; ea = wv; es = 1 << sz; tag = "R3";
    end else begin
      ek = 2; es = 1 << sz;
      b = int'(wv[15:8]); x = int'(wv[7:0]);
      ext = mode - 3;
      if (b >= 64 || x >= 64) begin
        ef = 1; ecn = 1; elat = 2; tag = "R8";
      end else begin
        ecn = 1 + ext;
        if (b != 0 && reg_sys(b) && um) begin
          ef = 2; elat = 3 + ext; tag = "R10";
        end else if (x != 0 && reg_sys(x) && um) begin
          ef = 2; elat = 4 + ext; tag = "R10";
        end else begin
          vb = (b == 0) ? 64'd0 : reg_raw(b);
          vx = (x == 0) ? 64'd0 : reg_raw(x);
          sc = (mode == 5) ? {{48{wv[31]}}, wv[31:16]} : 64'd1;
          dp = (mode == 5) ? {{48{wv[47]}}, wv[47:32]} :
               (mode == 4) ? {{48{wv[31]}}, wv[31:16]} : 64'd0;
          ea = vb + vx * sc + dp;
          elat = 5 + ext;
          tag = (mode == 3) ? "R5/R7" : "R6/R7";
          if (b == 0 || x == 0) tag = "R9/R7";
        end
      end
    end
  endtask

  task automatic run_op(input int mode, input int sz, input logic [63:0] wv,
                        input bit um, input bit gaps, input bit poke);
    int ef, ek, es, ecn, elat, k, lat;
    logic [63:0] ev, ea;
    string tag;
    bit acc;
    model(mode, sz, wv, um, ef, ek, ev, ea, es, ecn, elat, tag);
    @(negedge clk);
    user_mode = um;
    op_fmt    = {4'(mode), 4'(sz)};
    op_start  = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    k = 0; lat = 1;
    while (!done && lat < 60) begin
      op_start = (poke && lat == 2);
      if (poke && lat == 2) op_fmt = 8'hF0;
      wd_valid = (k < 4) && !(gaps && ($urandom % 3 == 0));
      wd_data  = (k < 4) ? wv[16*k +: 16] : 16'hFFFF;
      acc = wd_valid && wd_ready;
      @(negedge clk);
      if (acc) k++;
      lat++;
    end
    op_start = 1'b0;
    wd_valid = 1'b0;
    chk(tag, "done seen", 64'(done), 64'd1);
    chk(tag, "fault", 64'(res_fault), 64'(ef));
    chk(tag, "words consumed", 64'(k), 64'(ecn));
    if (!gaps) chk(poke ? "R12" : tag, "latency", 64'(lat), 64'(elat));
    if (ef == 0) begin
      chk(tag, "kind", 64'(res_kind), 64'(ek));
      if (ek == 2) begin
        chk(tag, "address", res_addr, ea);
        chk("R4", "size", 64'(res_size), 64'(es));
      end else begin
        chk(tag, "value", res_val, ev);
      end
    end
    @(negedge clk);
    chk("R12", "done single cycle", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int mode, sz, r, bi, xi;
    logic [63:0] wv;
    void'($urandom(32'd20240611));
    rst = 1'b1; op_start = 1'b0; op_fmt = 8'h00; user_mode = 1'b0;
    wd_valid = 1'b0; wd_data = 16'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12", "reset done", 64'(done), 64'd0);
    chk("R12", "reset busy", 64'(busy), 64'd0);
    chk("R12", "reset ready", 64'(wd_ready), 64'd0);
    chk("R12", "reset fault", 64'(res_fault), 64'd0);

    // directed corner cases
    run_op(0, 0, 64'h0000_0000_0000_0007, 0, 0, 0);      // R1
    run_op(0, 0, 64'h0000_0000_0000_0000, 0, 0, 0);      // R9 null as direct
    run_op(0, 0, 64'h0000_0000_0000_0040, 0, 0, 0);      // R8 index 64
    run_op(0, 0, 64'h0000_0000_0000_003D, 1, 0, 0);      // R10 system reg in user
    run_op(0, 0, 64'h0000_0000_0000_003D, 0, 0, 0);      // R10 allowed in supervisor
    run_op(1, 0, 64'h1122_3344_5566_7788, 0, 0, 0);      // R2
    run_op(2, 3, 64'h8000_0000_0000_1000, 0, 0, 0);      // R3
    run_op(2, 5, 64'h0, 0, 0, 0);                        // R4 bad size
    run_op(9, 0, 64'h0, 0, 0, 0);                        // R11
    run_op(3, 1, 64'h0000_0000_0000_0000, 1, 0, 0);      // R9 null pair
    run_op(4, 2, 64'h0000_0000_FFFE_0000, 0, 0, 0);      // R9 null pair, disp -2
    run_op(5, 0, 64'h0000_FFFE_FFFF_0A05, 0, 0, 0);      // R7 scale -1
    run_op(5, 3, 64'h0000_7FFF_8000_3F01, 0, 0, 0);      // R7 large scale
    run_op(3, 0, 64'h0000_0000_0000_4005, 0, 0, 0);      // R8 base 64
    run_op(3, 0, 64'h0000_0000_0000_053C, 1, 0, 0);      // R10 index sys
    run_op(1, 0, 64'hCAFE_F00D_1234_ABCD, 0, 0, 1);      // R12 start while busy

    // constrained random
    for (int n = 0; n < 400; n++) begin
      r = int'($urandom % 16);
      mode = (r < 14) ? (r % 6) : 6 + int'($urandom % 10);
      sz = ($urandom % 5 == 0) ? int'($urandom % 16) : int'($urandom % 4);
      wv = {$urandom, $urandom};
      bi = ($urandom % 10 == 0) ? int'($urandom % 256) : int'($urandom % 64);
      xi = ($urandom % 10 == 0) ? int'($urandom % 256) : int'($urandom % 64);
      if (mode == 0) wv[15:0] = 16'(bi);
      else if (mode >= 3) wv[15:0] = {8'(bi), 8'(xi)};
      run_op(mode, sz, wv, 1'($urandom % 2), ($urandom % 4 == 0), 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule